// File: doc/BRIEF.md
# Modem Status Tracker for a 16550-Style Serial Port

This block keeps the modem status byte of a 16550-style serial port. Four incoming modem lines (carrier detect, ring, data set ready, clear to send) are brought into the clock domain through a synchroniser. The block holds their present levels in the upper nibble of the byte and a sticky change flag for each line in the lower nibble. When the host reads the byte, the read strobe clears the change flags.

A loopback enable turns the external lines off and feeds the four modem control outputs of the port back into the status bits instead. The `delta_any` output tells the interrupt unit that at least one change flag is pending. The interrupt priority logic and the register address decoding sit outside this block.

Top module: `msr_status_unit`

## Requirements
- R1: On synchronous reset `status_q` is 0xB0 (carrier, data set ready and clear to send high, ring low, no change flags) and `delta_any` is 0.
- R2: Bit positions: 7 carrier detect, 6 ring, 5 data set ready, 4 clear to send, 3 carrier change, 2 ring trailing edge, 1 data set ready change, 0 clear to send change. A change on an external line shows in `status_q` on the third rising edge after it, because of two synchroniser stages and the status register.
- R3: A change in either direction on clear to send, data set ready or carrier detect sets change bit 0, 1 or 3 respectively.
- R4: Ring change bit 2 is set only when ring goes from 1 to 0. A 0-to-1 ring transition leaves it unchanged.
- R5: Change bits are sticky. They stay set when the line returns to its earlier level and when other lines change, until the byte is read.
- R6: While `rd_stb` is high, `status_q` shows the value before the read. On the edge that samples `rd_stb`, all four change bits are cleared.
- R7: If a line changes on the same edge as a read, the clear is applied first and the change bit for the new change is then set, so that change is kept.
- R8: With `loop_en` high the status levels come from the control outputs, one edge after they change: `ctl_out2` drives carrier detect, `ctl_out1` drives ring, `ctl_rts` drives clear to send and `ctl_dtr` drives data set ready. The external lines have no effect on the byte while loopback is on.
- R9: `delta_any` is high exactly when any of bits [3:0] of `status_q` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_cts | input | 1 | External clear-to-send level (asynchronous) |
| line_dsr | input | 1 | External data-set-ready level (asynchronous) |
| line_ri | input | 1 | External ring level (asynchronous) |
| line_dcd | input | 1 | External carrier-detect level (asynchronous) |
| ctl_dtr | input | 1 | Data-terminal-ready control output, looped to data set ready |
| ctl_rts | input | 1 | Request-to-send control output, looped to clear to send |
| ctl_out1 | input | 1 | General output 1, looped to ring |
| ctl_out2 | input | 1 | General output 2, looped to carrier detect |
| loop_en | input | 1 | Loopback select |
| rd_stb | input | 1 | One-cycle read strobe of the status byte |
| status_q | output | 8 | Modem status byte |
| delta_any | output | 1 | OR of the four change bits |

## Verification
A corrupted level nibble shows on `status_q[7:4]`, and it also sets a spurious change bit on the next edge that compares against it. A lost or stuck change bit shows on `status_q[3:0]` and `delta_any` as soon as the next read fails to clear it, or as soon as a later transition fails to set it. Because of this, every stimulus step in the bench samples the byte three to four edges after it is applied, and again right after each read. The read-collision case and the rising-ring case are driven through loopback, which has single-edge latency, so the exact edge on which they happen is under control.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int NLINES = 4;

    // Level nibble, most significant first: carrier, ring, data set ready, clear to send
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mline_t;

    // Change nibble, same bit order as the level nibble
    typedef struct packed {
        logic ddcd;
        logic teri;
        logic ddsr;
        logic dcts;
    } mdelta_t;

    typedef struct packed {
        mline_t  lvl;
        mdelta_t chg;
    } msr_t;

    localparam mline_t  LINE_RST  = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
    localparam mdelta_t DELTA_NONE = '{default: 1'b0};

    // Route the port's control outputs onto the status levels
    function automatic mline_t loop_map(input logic dtr, input logic rts,
                                        input logic out1, input logic out2);
        mline_t m;
        m.dcd = out2;
        m.ri  = out1;
        m.dsr = dtr;
        m.cts = rts;
        return m;
    endfunction

    // Change flags between two level samples; ring reports falling edges only
    function automatic mdelta_t change_flags(input mline_t prev, input mline_t nxt);
        mdelta_t d;
        d.ddcd = prev.dcd ^ nxt.dcd;
        d.ddsr = prev.dsr ^ nxt.dsr;
        d.dcts = prev.cts ^ nxt.cts;
        d.teri = prev.ri & ~nxt.ri;
        return d;
    endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stg;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= RST_VAL;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[LAST];

    initial begin
        assert (STAGES >= 1) else $error("msr_sync needs at least one stage");
    end
endmodule

// File: rtl/msr_src_sel.sv
module msr_src_sel
    import msr_pkg::*;
(
    input  logic   loop_en,
    input  mline_t ext_lines,
    input  logic   ctl_dtr,
    input  logic   ctl_rts,
    input  logic   ctl_out1,
    input  logic   ctl_out2,
    output mline_t src
);
    mline_t looped;

    always_comb begin
        looped = loop_map(ctl_dtr, ctl_rts, ctl_out1, ctl_out2);
        src    = loop_en ? looped : ext_lines;
    end
endmodule

// File: rtl/msr_delta.sv
module msr_delta
    import msr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  mline_t src,
    input  logic   rd_stb,
    output msr_t   q
);
    msr_t    r;
    mdelta_t fresh;
    mdelta_t kept;

    always_comb begin
        fresh = change_flags(r.lvl, src);
        // read clears first; a change on the same edge is then added back
        kept  = rd_stb ? DELTA_NONE : r.chg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r.lvl <= LINE_RST;
            r.chg <= DELTA_NONE;
        end else begin
            r.lvl <= src;
            r.chg <= kept | fresh;
        end
    end

    assign q = r;

    // Reset value check, R1
    logic rst_seen;
    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst_seen === 1'b1 && !rst) begin
            p_reset_value_r1: assert (q == 8'hB0)
                else $error("reset value wrong");
        end
    end

    // R5: without a read no change bit may drop
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_stb) |-> ((q[3:0] & $past(q[3:0])) == $past(q[3:0])));

    // R4: a ring rise alone never raises the trailing-edge bit
    p_ring_rise_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(q[6]) && !$past(q[2])) |-> !q[2]);

    // R3: a clear-to-send level change always leaves its change bit set
    p_cts_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (q[4] != $past(q[4])) |-> q[0]);

    // R6: after a read with no level movement, all change bits are clear
    p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_stb) && (q[7:4] == $past(q[7:4]))) |-> (q[3:0] == 4'h0));
endmodule

// File: rtl/msr_status_unit.sv
module msr_status_unit
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_cts,
    input  logic       line_dsr,
    input  logic       line_ri,
    input  logic       line_dcd,
    input  logic       ctl_dtr,
    input  logic       ctl_rts,
    input  logic       ctl_out1,
    input  logic       ctl_out2,
    input  logic       loop_en,
    input  logic       rd_stb,
    output logic [7:0] status_q,
    output logic       delta_any
);
    mline_t raw_lines;
    mline_t synced;
    mline_t src;
    msr_t   msr;

    assign raw_lines = '{dcd: line_dcd, ri: line_ri, dsr: line_dsr, cts: line_cts};

    msr_sync #(
        .WIDTH  (NLINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL(LINE_RST)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_lines),
        .q  (synced)
    );

    msr_src_sel u_sel (
        .loop_en  (loop_en),
        .ext_lines(synced),
        .ctl_dtr  (ctl_dtr),
        .ctl_rts  (ctl_rts),
        .ctl_out1 (ctl_out1),
        .ctl_out2 (ctl_out2),
        .src      (src)
    );

    msr_delta u_delta (
        .clk   (clk),
        .rst   (rst),
        .src   (src),
        .rd_stb(rd_stb),
        .q     (msr)
    );

    assign status_q  = msr;
    assign delta_any = |msr.chg;

    // R8: in loopback the level nibble follows the control outputs one edge later
    p_loop_map_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(loop_en) && !$past(rst)) |->
        (status_q[7:4] == {$past(ctl_out2), $past(ctl_out1), $past(ctl_dtr), $past(ctl_rts)}));
endmodule

// File: tb/test_msr_status_unit.sv
`timescale 1ns/1ps
module test_msr_status_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_cts = 1'b1, line_dsr = 1'b1, line_ri = 1'b0, line_dcd = 1'b1;
    logic ctl_dtr = 1'b0, ctl_rts = 1'b0, ctl_out1 = 1'b0, ctl_out2 = 1'b0;
    logic loop_en = 1'b0, rd_stb = 1'b0;
    logic [7:0] status_q;
    logic delta_any;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    msr_status_unit i_msr_status_unit (
        .clk(clk), .rst(rst),
        .line_cts(line_cts), .line_dsr(line_dsr), .line_ri(line_ri), .line_dcd(line_dcd),
        .ctl_dtr(ctl_dtr), .ctl_rts(ctl_rts), .ctl_out1(ctl_out1), .ctl_out2(ctl_out2),
        .loop_en(loop_en), .rd_stb(rd_stb),
        .status_q(status_q), .delta_any(delta_any)
    );

    // {loop, lines(dcd,ri,dsr,cts), ctl(out2,out1,rts,dtr), read, expected byte}
    localparam int NVEC = 14;
    localparam logic [17:0] VEC [0:NVEC-1] = '{
        {1'b0, 4'b1011, 4'b0000, 1'b0, 8'hB0},  // R2 idle
        {1'b0, 4'b1010, 4'b0000, 1'b1, 8'hA1},  // R3 cts drop
        {1'b0, 4'b1110, 4'b0000, 1'b0, 8'hE0},  // R4 ring rise, no flag
        {1'b0, 4'b1010, 4'b0000, 1'b0, 8'hA4},  // R4 ring fall
        {1'b0, 4'b0010, 4'b0000, 1'b1, 8'h2C},  // R3/R5 dcd fall, ring flag kept
        {1'b0, 4'b0000, 4'b0000, 1'b1, 8'h02},  // R3 dsr fall
        {1'b0, 4'b1111, 4'b0000, 1'b1, 8'hFB},  // R3 three rise, ring rise quiet
        {1'b1, 4'b1111, 4'b0000, 1'b1, 8'h0F},  // R8 loopback all low
        {1'b1, 4'b1111, 4'b1000, 1'b1, 8'h88},  // R8 out2 -> dcd
        {1'b1, 4'b1111, 4'b0100, 1'b1, 8'h48},  // R8 out1 -> ri
        {1'b1, 4'b1111, 4'b0010, 1'b1, 8'h15},  // R8 rts -> cts
        {1'b1, 4'b1111, 4'b0001, 1'b1, 8'h23},  // R8 dtr -> dsr
        {1'b1, 4'b0000, 4'b0001, 1'b0, 8'h20},  // R8 external ignored
        {1'b0, 4'b0000, 4'b0001, 1'b1, 8'h02}   // R2 back to external
    };

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic check_any(input string tag, input logic [7:0] byte_exp);
        check8({tag, " R9 delta_any"}, {7'd0, delta_any}, {7'd0, |byte_exp[3:0]});
    endtask

    task automatic drive(input logic lp, input logic [3:0] ln, input logic [3:0] ct);
        loop_en = lp;
        {line_dcd, line_ri, line_dsr, line_cts} = ln;
        {ctl_out2, ctl_out1, ctl_rts, ctl_dtr} = ct;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check8("R1 reset value", status_q, 8'hB0);
        check_any("R1", 8'hB0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][17], VEC[i][16:13], VEC[i][12:9]);
            repeat (4) @(negedge clk);
            check8($sformatf("vec%0d R2/R3/R4/R8 byte", i), status_q, VEC[i][7:0]);
            check_any($sformatf("vec%0d", i), VEC[i][7:0]);
            if (VEC[i][8]) begin
                rd_stb = 1'b1;
                #1;
                check8($sformatf("vec%0d R6 value during read", i), status_q, VEC[i][7:0]);
                @(negedge clk);
                rd_stb = 1'b0;
                check8($sformatf("vec%0d R6 cleared after read", i), status_q, {VEC[i][7:4], 4'h0});
                check_any($sformatf("vec%0d after read", i), 8'h00);
            end
        end

        // R5: cts pulse returns to its level, flag stays
        drive(1'b0, 4'b0001, 4'b0000);
        repeat (4) @(negedge clk);
        drive(1'b0, 4'b0000, 4'b0000);
        repeat (4) @(negedge clk);
        check8("R5 sticky after line returns", status_q, 8'h01);
        repeat (6) @(negedge clk);
        check8("R5 still held", status_q, 8'h01);

        // R7: clear and new change on the same edge, via loopback
        drive(1'b1, 4'b0000, 4'b0000);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check8("R7 setup cleared", status_q, 8'h00);
        rd_stb = 1'b1;
        ctl_rts = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check8("R7 change kept across read", status_q, 8'h11);
        check_any("R7", 8'h11);

        // R1: reset from a busy state
        drive(1'b0, 4'b1011, 4'b0000);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check8("R1 reset mid-run", status_q, 8'hB0);
        check_any("R1 mid-run", 8'hB0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #50000;
        checks++;
        failures++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule